// File: doc/BRIEF.md
# 1-Wire ROM-Layer Bus Monitor

This block watches a 1-Wire bus passively from above a link-layer receiver and decodes the network (ROM) layer. The link layer hands it two kinds of single-cycle events. One is a bus reset carrying the presence flag seen in the answer. The other is one received time slot carrying its bit value. A third strobe stands for any other link-layer event, and the monitor ignores it.

After each reset, the monitor assembles the 8-bit ROM command and classifies it. The command picks one of three follow-on phases:

- Some commands make it read a 64-bit device address directly.
- The search commands make it follow the three-slot search exchange.
- The skip-style commands take it straight to transport.

In transport it reports every received byte. An unknown command puts it into an error state, where every byte is reported as error data until the next reset.

Every result leaves the block as a registered strobe that lasts one clock cycle. Value outputs hold their last reported contents between strobes.

Top module: `owr_rom_monitor`

## Requirements
- R1: A reset event forces the command-receive state, clears the bit counter and returns the search exchange to its first slot. In the following cycle, `pres_vld_o` pulses with `pres_o` equal to the presence flag given with the event.
- R2: When a reset event and a bit event arrive in the same cycle, the reset wins. The bit is discarded, and the next 8 bits form a fresh command.
- R3: Bits are assembled least-significant first: the k-th bit after a reset is bit k of the command. On the 8th bit, `cmd_vld_o` pulses with the code on `cmd_code_o`. `cmd_known_o` is 1 for the ten codes listed in R4, R5 and R6, and 0 for all other codes.
- R4: Codes 0x33, 0x0F, 0x55, 0x69 and 0x96 lead to address collection, one bus bit per address bit. On the 64th bit, `rom_vld_o` pulses with the address on `rom_o`, least-significant first, and the monitor enters transport.
- R5: Codes 0xCC, 0x3C and 0xA5 enter transport directly, so the next 8 bits already form a data byte.
- R6: Codes 0xF0 and 0xEC start the search. Each address bit takes three bus bits: the true bit, its complement and the master's direction bit. `rom_o` is built from the direction bits. `srch_true_o` and `srch_comp_o` report the collected true and complement vectors. All of these are reported with the `rom_vld_o` pulse, after which the monitor enters transport.
- R7: At the end of a search, `srch_conflict_o` has a 1 at every position where both the true and complement bits were 0. `srch_absent_o` has a 1 at every position where both were 1.
- R8: In transport, every 8 bits pulse `data_vld_o` with the byte on `data_o`, least-significant first. The monitor stays in transport until a reset.
- R9: Any other command code enters the error state. There, every 8 bits pulse `err_vld_o` with the byte on `err_o`, until a reset.
- R10: A miscellaneous event (`misc_evt_i`) advances no counter, produces no strobe and does not disturb the byte or address in progress.
- R11: All result strobes are registered and last exactly one cycle. At most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_evt_i | input | 1 | Bus reset/presence event strobe |
| presence_i | input | 1 | Presence flag carried with the reset event |
| bit_evt_i | input | 1 | Received-bit event strobe |
| bit_val_i | input | 1 | Value of the received bit |
| misc_evt_i | input | 1 | Any other link-layer event strobe (ignored) |
| pres_vld_o | output | 1 | Reset reported |
| pres_o | output | 1 | Reported presence flag |
| cmd_vld_o | output | 1 | Command byte complete |
| cmd_code_o | output | 8 | Command code |
| cmd_known_o | output | 1 | Command recognised |
| rom_vld_o | output | 1 | Address complete |
| rom_o | output | ROM_BITS | Device address |
| srch_true_o | output | ROM_BITS | True bits seen during search |
| srch_comp_o | output | ROM_BITS | Complement bits seen during search |
| srch_conflict_o | output | ROM_BITS | Positions where true and complement were both 0 |
| srch_absent_o | output | ROM_BITS | Positions where true and complement were both 1 |
| data_vld_o | output | 1 | Transport byte complete |
| data_o | output | 8 | Transport byte |
| err_vld_o | output | 1 | Error-state byte complete |
| err_o | output | 8 | Error-state byte |

## Verification
The bench builds the monitor with the default ROM_BITS of 64, which brings the full 64-bit address within reach, including the 192-slot search exchange. At that width the last address bit exercises both the top index of the shared shift register and the wrap of the bit counter. Random transactions draw every listed command code and random unknown codes. Some of them are cut short by resets in the middle of a command, an address or a search. The search slots are random, so every true/complement pairing appears at many positions, and a directed run places them at bit 0 and bit 63.

// File: rtl/owr_mon_pkg.sv
package owr_mon_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_CMD   = 3'd0,
    ST_ROM   = 3'd1,
    ST_SRCH  = 3'd2,
    ST_XPORT = 3'd3,
    ST_ERR   = 3'd4
  } mon_state_e;

  typedef enum logic [1:0] {
    TRI_TRUE = 2'd0,
    TRI_COMP = 2'd1,
    TRI_DIR  = 2'd2
  } tri_step_e;
endpackage

// File: rtl/owr_cmd_decode.sv
module owr_cmd_decode
  import owr_mon_pkg::*;
(
  input  logic [BYTE_W-1:0] code_i,
  output mon_state_e        next_st_o,
  output logic              known_o
);
  always_comb begin
    known_o   = 1'b1;
    next_st_o = ST_ERR;
    case (code_i)
      8'h33, 8'h0F, 8'h55, 8'h69, 8'h96: next_st_o = ST_ROM;
      8'hCC, 8'h3C, 8'hA5:               next_st_o = ST_XPORT;
      8'hF0, 8'hEC:                      next_st_o = ST_SRCH;
      default: begin
        next_st_o = ST_ERR;
        known_o   = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/owr_search_track.sv
module owr_search_track
  import owr_mon_pkg::*;
#(
  parameter int ROM_BITS = 64,
  parameter int CNT_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                bit_evt_i,
  input  logic                bit_val_i,
  input  logic [CNT_W-1:0]    idx_i,
  output logic                dir_step_o,
  output logic [ROM_BITS-1:0] true_o,
  output logic [ROM_BITS-1:0] comp_o
);
  tri_step_e           step_q, step_d;
  logic [ROM_BITS-1:0] true_q, true_d, comp_q, comp_d;

  always_comb begin
    step_d = step_q;
    true_d = true_q;
    comp_d = comp_q;
    if (clr_i) begin
      step_d = TRI_TRUE;
    end else if (bit_evt_i) begin
      case (step_q)
        TRI_TRUE: begin
          true_d[idx_i] = bit_val_i;
          step_d        = TRI_COMP;
        end
        TRI_COMP: begin
          comp_d[idx_i] = bit_val_i;
          step_d        = TRI_DIR;
        end
        default: step_d = TRI_TRUE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= TRI_TRUE;
      true_q <= '0;
      comp_q <= '0;
    end else begin
      step_q <= step_d;
      true_q <= true_d;
      comp_q <= comp_d;
    end
  end

  assign dir_step_o = (step_q == TRI_DIR);
  assign true_o     = true_q;
  assign comp_o     = comp_q;

  // Slot order is true, then complement, then direction.
  assert_slot_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_evt_i && !clr_i && step_q == TRI_TRUE) |=> step_q == TRI_COMP);
  assert_slot_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_evt_i && !clr_i && step_q == TRI_DIR) |=> step_q == TRI_TRUE);
  assert_slot_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> step_q == TRI_TRUE);
endmodule

// File: rtl/owr_rom_monitor.sv
module owr_rom_monitor
  import owr_mon_pkg::*;
#(
  parameter int ROM_BITS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rst_evt_i,
  input  logic                presence_i,
  input  logic                bit_evt_i,
  input  logic                bit_val_i,
  input  logic                misc_evt_i,
  output logic                pres_vld_o,
  output logic                pres_o,
  output logic                cmd_vld_o,
  output logic [BYTE_W-1:0]   cmd_code_o,
  output logic                cmd_known_o,
  output logic                rom_vld_o,
  output logic [ROM_BITS-1:0] rom_o,
  output logic [ROM_BITS-1:0] srch_true_o,
  output logic [ROM_BITS-1:0] srch_comp_o,
  output logic [ROM_BITS-1:0] srch_conflict_o,
  output logic [ROM_BITS-1:0] srch_absent_o,
  output logic                data_vld_o,
  output logic [BYTE_W-1:0]   data_o,
  output logic                err_vld_o,
  output logic [BYTE_W-1:0]   err_o
);
  localparam int CNT_W  = $clog2(ROM_BITS);
  localparam int BIDX_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_ROM  = CNT_W'(ROM_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(BYTE_W - 1);

  mon_state_e          state_q, state_d, dec_state;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [ROM_BITS-1:0] shift_q, shift_d;
  logic [BYTE_W-1:0]   byte_asm;
  logic                dec_known, dir_step, srch_evt;
  logic [ROM_BITS-1:0] trk_true, trk_comp;

  logic                pres_vld_q, pres_vld_d, pres_q, pres_d;
  logic                cmd_vld_q, cmd_vld_d, known_q, known_d;
  logic [BYTE_W-1:0]   code_q, code_d, data_q, data_d, err_q, err_d;
  logic                rom_vld_q, rom_vld_d, data_vld_q, data_vld_d, err_vld_q, err_vld_d;
  logic [ROM_BITS-1:0] rom_q, rom_d, st_q, st_d, sc_q, sc_d, cf_q, cf_d, ab_q, ab_d;

  // Byte in progress including the bit arriving this cycle.
  always_comb begin
    byte_asm = shift_q[BYTE_W-1:0];
    byte_asm[cnt_q[BIDX_W-1:0]] = bit_val_i;
  end

  owr_cmd_decode u_dec (
    .code_i    (byte_asm),
    .next_st_o (dec_state),
    .known_o   (dec_known)
  );

  assign srch_evt = bit_evt_i && !rst_evt_i && (state_q == ST_SRCH);

  owr_search_track #(.ROM_BITS(ROM_BITS), .CNT_W(CNT_W)) u_srch (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (rst_evt_i),
    .bit_evt_i  (srch_evt),
    .bit_val_i  (bit_val_i),
    .idx_i      (cnt_q),
    .dir_step_o (dir_step),
    .true_o     (trk_true),
    .comp_o     (trk_comp)
  );

  always_comb begin
    state_d = state_q;  cnt_d = cnt_q;  shift_d = shift_q;
    pres_vld_d = 1'b0;  cmd_vld_d = 1'b0;  rom_vld_d = 1'b0;
    data_vld_d = 1'b0;  err_vld_d = 1'b0;
    pres_d = pres_q;  code_d = code_q;  known_d = known_q;
    data_d = data_q;  err_d = err_q;  rom_d = rom_q;
    st_d = st_q;  sc_d = sc_q;  cf_d = cf_q;  ab_d = ab_q;
    if (rst_evt_i) begin
      state_d    = ST_CMD;
      cnt_d      = '0;
      pres_vld_d = 1'b1;
      pres_d     = presence_i;
    end else if (bit_evt_i) begin
      if (state_q == ST_ROM || (state_q == ST_SRCH && dir_step)) begin
        shift_d[cnt_q] = bit_val_i;
        if (cnt_q == LAST_ROM) begin
          cnt_d     = '0;
          rom_vld_d = 1'b1;
          rom_d     = shift_d;
          state_d   = ST_XPORT;
          if (state_q == ST_SRCH) begin
            st_d = trk_true;
            sc_d = trk_comp;
            cf_d = ~trk_true & ~trk_comp;
            ab_d = trk_true & trk_comp;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (state_q != ST_SRCH) begin
        shift_d[BYTE_W-1:0] = byte_asm;
        if (cnt_q == LAST_BYTE) begin
          cnt_d = '0;
          case (state_q)
            ST_CMD: begin
              cmd_vld_d = 1'b1;
              code_d    = byte_asm;
              known_d   = dec_known;
              state_d   = dec_state;
            end
            ST_XPORT: begin
              data_vld_d = 1'b1;
              data_d     = byte_asm;
            end
            default: begin
              err_vld_d = 1'b1;
              err_d     = byte_asm;
            end
          endcase
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CMD;  cnt_q <= '0;  shift_q <= '0;
      pres_vld_q <= 1'b0;  cmd_vld_q <= 1'b0;  rom_vld_q <= 1'b0;
      data_vld_q <= 1'b0;  err_vld_q <= 1'b0;
      pres_q <= 1'b0;  code_q <= '0;  known_q <= 1'b0;
      data_q <= '0;  err_q <= '0;  rom_q <= '0;
      st_q <= '0;  sc_q <= '0;  cf_q <= '0;  ab_q <= '0;
    end else begin
      state_q <= state_d;  cnt_q <= cnt_d;  shift_q <= shift_d;
      pres_vld_q <= pres_vld_d;  cmd_vld_q <= cmd_vld_d;  rom_vld_q <= rom_vld_d;
      data_vld_q <= data_vld_d;  err_vld_q <= err_vld_d;
      pres_q <= pres_d;  code_q <= code_d;  known_q <= known_d;
      data_q <= data_d;  err_q <= err_d;  rom_q <= rom_d;
      st_q <= st_d;  sc_q <= sc_d;  cf_q <= cf_d;  ab_q <= ab_d;
    end
  end

  assign pres_vld_o = pres_vld_q;  assign pres_o = pres_q;
  assign cmd_vld_o = cmd_vld_q;  assign cmd_code_o = code_q;  assign cmd_known_o = known_q;
  assign rom_vld_o = rom_vld_q;  assign rom_o = rom_q;
  assign srch_true_o = st_q;  assign srch_comp_o = sc_q;
  assign srch_conflict_o = cf_q;  assign srch_absent_o = ab_q;
  assign data_vld_o = data_vld_q;  assign data_o = data_q;
  assign err_vld_o = err_vld_q;  assign err_o = err_q;

  assert_reset_report_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt_i |=> pres_vld_o && pres_o == $past(presence_i) && state_q == ST_CMD && cnt_q == '0);
  assert_reset_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_evt_i && bit_evt_i) |=> !cmd_vld_o && !rom_vld_o && !data_vld_o && !err_vld_o);
  assert_rom_to_xport_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rom_vld_o |-> state_q == ST_XPORT);
  assert_data_in_xport_R8: assert property (@(posedge clk) disable iff (!rst_n)
    data_vld_o |-> state_q == ST_XPORT);
  assert_unknown_to_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_o && !cmd_known_o) |-> state_q == ST_ERR);
  assert_err_in_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld_o |-> state_q == ST_ERR);
  assert_misc_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (misc_evt_i && !rst_evt_i && !bit_evt_i) |=> $stable(cnt_q) && $stable(state_q)
      && !cmd_vld_o && !rom_vld_o && !data_vld_o && !err_vld_o && !pres_vld_o);
  assert_single_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pres_vld_o, cmd_vld_o, rom_vld_o, data_vld_o, err_vld_o}));
endmodule

// File: tb/owr_rom_monitor_tb.sv
`timescale 1ns/1ps
module owr_rom_monitor_tb_top;
  localparam int RB = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_evt = 1'b0, presence = 1'b0, bit_evt = 1'b0, bit_val = 1'b0, misc_evt = 1'b0;
  logic pres_vld, pres, cmd_vld, cmd_known, rom_vld, data_vld, err_vld;
  logic [7:0] cmd_code, data, err;
  logic [RB-1:0] rom, s_true, s_comp, s_conf, s_abs;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  owr_rom_monitor #(.ROM_BITS(RB)) dut_i (
    .clk(clk), .rst_n(rst_n), .rst_evt_i(rst_evt), .presence_i(presence),
    .bit_evt_i(bit_evt), .bit_val_i(bit_val), .misc_evt_i(misc_evt),
    .pres_vld_o(pres_vld), .pres_o(pres), .cmd_vld_o(cmd_vld), .cmd_code_o(cmd_code),
    .cmd_known_o(cmd_known), .rom_vld_o(rom_vld), .rom_o(rom), .srch_true_o(s_true),
    .srch_comp_o(s_comp), .srch_conflict_o(s_conf), .srch_absent_o(s_abs),
    .data_vld_o(data_vld), .data_o(data), .err_vld_o(err_vld), .err_o(err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] strobes();
    return {pres_vld, cmd_vld, rom_vld, data_vld, err_vld};
  endfunction

  // 0 address read, 1 skip to transport, 2 search, 3 unknown
  function automatic int exp_class(input logic [7:0] c);
    case (c)
      8'h33, 8'h0F, 8'h55, 8'h69, 8'h96: return 0;
      8'hCC, 8'h3C, 8'hA5: return 1;
      8'hF0, 8'hEC: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [7:0] pick_cmd(input int i);
    case (i)
      0: return 8'h33;  1: return 8'h0F;  2: return 8'h55;  3: return 8'h69;
      4: return 8'h96;  5: return 8'hCC;  6: return 8'h3C;  7: return 8'hA5;
      8: return 8'hF0;  9: return 8'hEC;
      default: return 8'($urandom);
    endcase
  endfunction

  // One event, sampled on the falling edge after the registering edge.
  task automatic pulse(input bit r, input bit p, input bit b, input bit v, input bit m);
    @(negedge clk);
    rst_evt = r; presence = p; bit_evt = b; bit_val = v; misc_evt = m;
    @(negedge clk);
    rst_evt = 0; bit_evt = 0; misc_evt = 0;
  endtask

  task automatic maybe_misc();
    if ($urandom % 8 == 0) begin
      pulse(0, 0, 0, 0, 1);
      chk(strobes() == 5'b0, "R10 misc event produced strobe", 64'(strobes()), 0);
    end
  endtask

  task automatic send_bit(input bit v);
    maybe_misc();
    pulse(0, 0, 1, v, 0);
  endtask

  task automatic send_rst(input bit p);
    pulse(1, p, 0, 0, 0);
    chk(pres_vld && pres == p && strobes() == 5'b10000, "R1 presence report",
        {59'b0, strobes()} << 1 | 64'(pres), {59'b0, 5'b10000} << 1 | 64'(p));
  endtask

  // Sends 8 bits LSB first; returns strobes seen after the last bit.
  task automatic send_byte(input logic [7:0] b, output logic [4:0] s);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    s = strobes();
  endtask

  task automatic idle_check();
    pulse(0, 0, 0, 0, 0);
    chk(strobes() == 5'b0, "R11 strobe longer than one cycle", 64'(strobes()), 0);
  endtask

  task automatic send_cmd(input logic [7:0] c);
    logic [4:0] s;
    send_byte(c, s);
    chk(s == 5'b01000 && cmd_code == c, "R3 command strobe/code", {56'b0, cmd_code}, {56'b0, c});
    chk(cmd_known == (exp_class(c) != 3), "R3 known flag", 64'(cmd_known), 64'(exp_class(c) != 3));
  endtask

  task automatic do_read(input logic [63:0] a);
    for (int i = 0; i < RB; i++) send_bit(a[i]);
    chk(rom_vld && rom == a, "R4 address read", rom, a);
  endtask

  task automatic do_search(input logic [63:0] t, input logic [63:0] c, input logic [63:0] d);
    for (int i = 0; i < RB; i++) begin
      send_bit(t[i]); send_bit(c[i]); send_bit(d[i]);
    end
    chk(rom_vld && rom == d, "R6 search address from direction bits", rom, d);
    chk(s_true == t, "R6 true vector", s_true, t);
    chk(s_comp == c, "R6 complement vector", s_comp, c);
    chk(s_conf == (~t & ~c), "R7 conflict flags", s_conf, ~t & ~c);
    chk(s_abs == (t & c), "R7 absent flags", s_abs, t & c);
  endtask

  task automatic do_bytes(input int cls, input int n);
    logic [4:0] s;
    for (int k = 0; k < n; k++) begin
      logic [7:0] b = 8'($urandom);
      send_byte(b, s);
      if (cls == 3)
        chk(s == 5'b00001 && err == b, "R9 error byte", {56'b0, err}, {56'b0, b});
      else
        chk(s == 5'b00010 && data == b, "R8 transport byte", {56'b0, data}, {56'b0, b});
    end
  endtask

  task automatic transaction(input logic [7:0] c, input int nbytes);
    int cls = exp_class(c);
    send_rst($urandom % 2 == 1);
    send_cmd(c);
    if (cls == 0) do_read({$urandom, $urandom});
    else if (cls == 2) do_search({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
    if (cls == 1 && nbytes == 0) nbytes = 1; // R5 skip-style goes straight to bytes
    do_bytes(cls, nbytes);
    idle_check();
  endtask

  initial begin
    logic [4:0] s;
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    chk(strobes() == 5'b0 && cmd_code == 0 && rom == 0, "R11 reset state", 64'(strobes()), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: each skip-style code leads to a data byte straight away
    transaction(8'hCC, 1);
    transaction(8'h3C, 2);
    transaction(8'hA5, 1);
    // R9: unknown code, then error bytes
    transaction(8'h00, 3);
    // R2: reset and bit together in the middle of a command
    send_rst(1);
    send_bit(1); send_bit(0); send_bit(1);
    pulse(1, 0, 1, 1, 0);
    chk(strobes() == 5'b10000 && pres == 0, "R2 reset wins over bit", 64'(strobes()), 64'(5'b10000));
    send_cmd(8'h55);
    do_read(64'h0123_4567_89AB_CDEF);
    do_bytes(1, 1);
    // R1: reset in the middle of a search, then a full search with the corner pairings
    send_rst(0);
    send_cmd(8'hF0);
    for (int i = 0; i < 20; i++) send_bit(i[0]);
    send_rst(1);
    send_cmd(8'hEC);
    do_search(64'h8000_0000_0000_0002, 64'h8000_0000_0000_0004, 64'h5A5A_0F0F_3C3C_9999);
    do_bytes(1, 1);
    // R1: reset in the middle of an address read
    send_rst(0);
    send_cmd(8'h33);
    for (int i = 0; i < 30; i++) send_bit(1'b1);
    send_rst(1);
    send_cmd(8'h69);
    do_read(64'hFFFF_0000_A5A5_0001);
    // R10: miscellaneous events inside a byte do not shift it
    pulse(0, 0, 0, 0, 1);
    chk(strobes() == 5'b0, "R10 misc event produced strobe", 64'(strobes()), 0);
    send_byte(8'hC3, s);
    chk(s == 5'b00010 && data == 8'hC3, "R10 byte intact after misc", {56'b0, data}, 64'hC3);

    for (int t = 0; t < 40; t++) transaction(pick_cmd($urandom % 14), $urandom % 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule